// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

A small synchronous memory in which every access, read or write, moves its data over the bus exactly two clock cycles after the command and address are taken. Because write data trails its command by the same distance as read data, a shared bidirectional bus can alternate between reads and writes on consecutive cycles with no idle slot for turnaround.

Address, command, byte-lane write selects and write data are all registered on the rising clock edge. A clock-enable input, active low, freezes the whole pipeline. A new access starts only when load is requested and all three chip enables are in their active state. Operations already in flight always finish, even after a deselect. The bus itself is modelled as separate input, output and drive-enable signals. An asynchronous output-enable input can cut the drive at any moment. Address sequencing for bursts is supplied from outside on the address port; the advance command only carries the previous access type forward.

Top module: `zt_sram`

## Requirements
- R1: A read issued in cycle t (clk_en_n low in cycles t and t+1) drives the stored word on dout with dout_en high during cycle t+2, provided oe_n is low.
- R2: A write issued in cycle t takes din at the end of cycle t+2; lane i (din bits 9i+8 down to 9i) is written only when bw_n[i] is 0, and unselected lanes keep their contents.
- R3: While clk_en_n is 1, all synchronous inputs are ignored: no command enters, no write lands in memory, and dout and dout_en keep their values.
- R4: With ld_n low, a new access starts only when cs_a_n=0, cs_b=1 and cs_c_n=0; any other combination is a deselect, and dout_en is low in its data cycle.
- R5: A deselect does not cancel accesses already issued; they complete in their own data cycles.
- R6: dout_en is low during the data cycle of a write, so the bus is released two cycles after a write is issued.
- R7: oe_n acts without a clock: while it is 1, dout_en is 0 at once.
- R8: A read issued the cycle after a write to the same address returns the newly written lanes merged with the old contents of the masked lanes.
- R9: With ld_n high, the chip enables are ignored and the access continues the previous command's type and validity, using the address and byte selects now on the ports.
- R10: After reset the pipeline holds no access and dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes everything |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low: load a new command; high: advance the previous one |
| we_n | input | 1 | Access type: 1 read, 0 write |
| bw_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, taken two cycles after the command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The hardest case to reach is a read that follows a write to the same word by one cycle, because the read fetches from the array at the same edge that the write lands. Any error in the bypass shows only when byte masks leave some lanes old and some new. The bench sweeps every mask against that pairing. It also interleaves clock-enable stalls from a pseudo-random sequence, so that held data cycles fall on writes, reads and deselects alike. A reference memory and a two-deep command model in the bench derive every expected value.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_kind_e;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              ld_n,
   input  logic              ce_ok,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   output op_kind_e          s1_kind,
   output logic [ADDR_W-1:0] s1_addr,
   output op_kind_e          s2_kind,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_bw_n
);
   op_kind_e         next_kind;
   logic [LANES-1:0] s1_bw_n;

   always_comb begin
      if (!ld_n) next_kind = ce_ok ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
      else       next_kind = s1_kind;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_kind <= OP_IDLE;
         s2_kind <= OP_IDLE;
      end else if (!hold) begin
         s1_kind <= next_kind;
         s2_kind <= s1_kind;
      end
   end

   always_ff @(posedge clk) begin
      if (!hold) begin
         s1_addr <= addr;
         s1_bw_n <= bw_n;
         s2_addr <= s1_addr;
         s2_bw_n <= s1_bw_n;
      end
   end

   // R4
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !ld_n && !ce_ok) |=> (s1_kind == OP_IDLE));
   // R5
   pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && s1_kind != OP_IDLE) |=> (s2_kind == $past(s1_kind)));
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(s1_kind) && $stable(s2_kind)));
   // R9
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && ld_n) |=> (s1_kind == $past(s1_kind)));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_bw_n,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic same_word;
   assign same_word = (wr_addr == rd_addr);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;
      logic              lane_wr;

      assign lane_wr = en && wr_en && !wr_bw_n[i];

      always_ff @(posedge clk) begin
         if (lane_wr) mem[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else if (en && rd_en)
            rd_q <= (lane_wr && same_word) ? wr_data[i*LANE_W +: LANE_W] : mem[rd_addr];
      end

      assign rd_data[i*LANE_W +: LANE_W] = rd_q;

      // R8
      bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en && wr_en && rd_en && same_word && !wr_bw_n[i])
            |=> (rd_q == $past(wr_data[i*LANE_W +: LANE_W])));
   end

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rd_data));
endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    cs_a_n,
   input  logic                    cs_b,
   input  logic                    cs_c_n,
   input  logic                    ld_n,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DW = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("zt_sram: ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("zt_sram: LANES must lie in 1..16");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("zt_sram: LANE_W must be positive");
   end

   op_kind_e          s1_kind, s2_kind;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s2_bw_n;
   logic [DW-1:0]     rd_data;
   logic              ce_ok, issue_rd;

   assign ce_ok    = !cs_a_n && cs_b && !cs_c_n;
   assign issue_rd = !clk_en_n && !ld_n && ce_ok && we_n;

   zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .hold(clk_en_n), .ld_n(ld_n), .ce_ok(ce_ok),
      .we_n(we_n), .addr(addr), .bw_n(bw_n),
      .s1_kind(s1_kind), .s1_addr(s1_addr),
      .s2_kind(s2_kind), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
   );

   zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .en(!clk_en_n),
      .wr_en(s2_kind == OP_WRITE), .wr_addr(s2_addr), .wr_bw_n(s2_bw_n), .wr_data(din),
      .rd_en(s1_kind == OP_READ), .rd_addr(s1_addr), .rd_data(rd_data)
   );

   assign dout    = rd_data;
   assign dout_en = (s2_kind == OP_READ) && !oe_n;

   // R7
   always_comb begin
      if (oe_n) oe_async_chk: assert (!dout_en);
   end
   // R6
   turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_kind == OP_WRITE) |-> !dout_en);
   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(issue_rd, 2) && $past(!clk_en_n) && !oe_n) |-> dout_en);
endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/100ps
module tb_zt_sram;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n, clk_en_n, cs_a_n, cs_b, cs_c_n, ld_n, we_n, oe_n;
   logic [NL-1:0] bw_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic          dout_en;

   always #2.5 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
      .cs_c_n(cs_c_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
   );

   int nchk = 0, nerr = 0;
   bit done = 0;
   logic [DW-1:0] ref_mem [DEPTH];
   logic [31:0] rng = 32'h1234_5678;
   int seq = 0;
   // model: p1 = issued one cycle ago, p2 = issued two cycles ago
   bit p1v, p1wr, p2v, p2wr;
   int p1a, p2a;
   bit [NL-1:0] p1b, p2b;

   function automatic logic [DW-1:0] wpat(int a, int s);
      logic [DW-1:0] v;
      for (int i = 0; i < NL; i++) v[i*LW +: LW] = LW'((a * 29 + s * 53 + i * 97) ^ 'h15A);
      return v;
   endfunction

   task automatic nxt();
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock cycle; entered just after a rising edge
   task automatic step(input bit en, input bit ldn, input bit [2:0] cs, input bit wen,
                       input int a, input bit [NL-1:0] bwn, input bit oen,
                       input bit probe, input string tag);
      logic [DW-1:0] cur;
      bit exp_en, nv, nwr;
      nxt();
      clk_en_n = !en; ld_n = ldn; {cs_a_n, cs_b, cs_c_n} = cs; we_n = wen;
      addr = AW'(a); bw_n = bwn; oe_n = oen;
      seq++;
      cur = (p2v && p2wr) ? wpat(p2a, seq) : {rng[3:0], rng, rng[31:28]};
      din = cur;
      @(negedge clk);
      exp_en = p2v && !p2wr && !oen;
      chk(dout_en === exp_en, tag, DW'(dout_en), DW'(exp_en));
      if (exp_en) chk(dout === ref_mem[p2a], tag, dout, ref_mem[p2a]);
      if (probe) begin
         oe_n = !oen; #0.5;
         chk(dout_en === (p2v && !p2wr && oen), "R7", DW'(dout_en), DW'(p2v && !p2wr && oen));
         oe_n = oen;
      end
      @(posedge clk); #1;
      if (en) begin
         if (p2v && p2wr)
            for (int i = 0; i < NL; i++)
               if (!p2b[i]) ref_mem[p2a][i*LW +: LW] = cur[i*LW +: LW];
         if (!ldn) begin nv = (cs == 3'b010); nwr = !wen; end
         else begin nv = p1v; nwr = p1wr; end
         p2v = p1v; p2wr = p1wr; p2a = p1a; p2b = p1b;
         p1v = nv; p1wr = nwr; p1a = a; p1b = bwn;
      end
   endtask

   task automatic rd(input int a, input string tag);
      step(1, 0, 3'b010, 1, a, '1, 0, 0, tag);
   endtask
   task automatic wr(input int a, input bit [NL-1:0] bwn, input string tag);
      step(1, 0, 3'b010, 0, a, bwn, 0, 0, tag);
   endtask
   task automatic idle(input string tag);
      step(1, 0, 3'b111, 1, 0, '1, 0, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; clk_en_n = 0; {cs_a_n, cs_b, cs_c_n} = 3'b111; ld_n = 0; we_n = 1;
      bw_n = '1; addr = '0; din = '0; oe_n = 0;
      p1v = 0; p2v = 0; p1wr = 0; p2wr = 0; p1a = 0; p2a = 0; p1b = '1; p2b = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R10: empty pipeline after reset
      for (int k = 0; k < 3; k++) idle("R10");

      // R2: fill all words, full lanes, back to back; R1: read all back
      for (int a = 0; a < DEPTH; a++) wr(a, '0, "R2");
      for (int a = 0; a < DEPTH; a++) rd(a, "R1");
      idle("R1"); idle("R1");

      // R2: every byte mask against read-back
      for (int m = 0; m < 16; m++) wr(m, NL'(m), "R2");
      for (int m = 0; m < 16; m++) rd(m, "R2");
      idle("R2"); idle("R2");

      // R8 and R6: write then read same word next cycle, all masks
      for (int m = 0; m < 16; m++) begin
         wr(20 + m, NL'(m), "R6");
         rd(20 + m, "R8");
      end
      idle("R8"); idle("R8");
      // R6: read then write alternating, no gaps
      for (int a = 40; a < 48; a++) begin
         rd(a, "R6");
         wr(a + 8, NL'(a), "R6");
      end
      idle("R6"); idle("R6");

      // R4: every chip-enable combination
      for (int c = 0; c < 8; c++) begin
         step(1, 0, 3'(c), 1, c, '1, 0, 0, "R4");
         idle("R4");
      end
      for (int c = 0; c < 8; c++) step(1, 0, 3'(c), 0, 60, 4'h0, 0, 0, "R4");
      idle("R4"); idle("R4");
      rd(60, "R4"); idle("R4"); idle("R4");

      // R5: deselect right after issue, pending still completes
      wr(5, 4'b0101, "R5"); rd(6, "R5"); idle("R5"); idle("R5"); rd(5, "R5"); idle("R5"); idle("R5");

      // R9: advance continues access type, ignoring chip enables
      rd(10, "R9");
      step(1, 1, 3'b111, 0, 11, '0, 0, 0, "R9");
      step(1, 1, 3'b101, 0, 12, '0, 0, 0, "R9");
      wr(30, 4'b0011, "R9");
      step(1, 1, 3'b111, 1, 31, 4'b1100, 0, 0, "R9");
      idle("R9");
      step(1, 1, 3'b010, 1, 33, '1, 0, 0, "R9");
      idle("R9"); idle("R9");
      rd(30, "R9"); rd(31, "R9"); rd(33, "R9"); idle("R9"); idle("R9");

      // R7: async output enable at various points
      for (int a = 0; a < 6; a++) step(1, 0, 3'b010, 1, a, '1, a[0], 1, "R7");
      idle("R7"); idle("R7");

      // R3: stalls mixed with random traffic, garbage during stalls
      for (int k = 0; k < 400; k++) begin
         bit en;
         nxt();
         en = (rng[1:0] != 2'b00);
         if (!en)
            step(0, rng[4], rng[7:5], rng[8], int'(rng[14:9]), rng[18:15], 0, 0, "R3");
         else if (rng[20:19] == 2'b00)
            idle("R3");
         else if (rng[21])
            step(1, rng[22] & rng[23], 3'b010, 0, int'(rng[29:24]), rng[18:15], 0, 0, "R3");
         else
            step(1, rng[22] & rng[23], 3'b010, 1, int'(rng[29:24]), '1, rng[30] & rng[31], 0, "R3");
      end
      for (int k = 0; k < 3; k++) idle("R3");
      for (int a = 0; a < DEPTH; a++) rd(a, "R3");
      idle("R3"); idle("R3");

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule